// File: doc/BRIEF.md
# Supervisor Trap Context Switcher

This block sits beside a small 8-bit CPU core and moves it into and out of a privileged supervisor mode with no software save or restore. When a trap is requested and the core reaches an instruction boundary, the whole architectural state is copied into a shadow bank in a single clock. The state is the accumulator, two index registers, the stack pointer, the flags, the program counter and a set of memory-mapping registers. In the same clock the live state takes a fixed supervisor configuration. The trap is invisible to the interrupted program: when supervisor code stores to the exit trigger address, the shadow bank is copied back in one clock, and the program resumes exactly where it stopped.

Traps come from a general request line and from a keyboard-derived event line. Requests that arrive while the supervisor is running, or between instruction boundaries, are held until they can be taken. The block also owns a protected configuration byte whose bit 0 enables a display overlay. Only supervisor mode can change it. Writes to that byte, and to the exit trigger, are dropped when they come from user mode. The CPU datapath is modelled as a register bundle: the core commits new state through an update port, and it reads the live state back from `state_q`.

Top module: `trap_ctx_switch`

## Requirements
- R1: While reset is held, and after it is released, `sup_mode`, `enter_pulse` and `exit_pulse` are 0, and `state_q` and `cfg_q` are all zeros.
- R2: A trap is taken when three things hold in the same cycle: `sup_mode` is 0, `instr_boundary` is 1, and `trap_req`, `key_evt` or a held request is active. In the cycle after that edge, `sup_mode` is 1 and `enter_pulse` is 1.
- R3: On entry, `state_q` takes the supervisor image and every other field keeps the captured value. The state layout is: a [7:0], x [15:8], y [23:16], sp [31:24], flags [39:32], pc [55:40], and mapping register k at [56+16k +: 16]. The supervisor image sets sp=SUP_SP, flags=SUP_FLAGS, pc=SUP_PC and mapping register k = SUP_MAP_BASE+k.
- R4: The state captured on entry is the state in effect at the trap boundary. That is `upd_state` if `upd_en` is 1 in the entry cycle, and `state_q` otherwise.
- R5: A write with `wr_addr`=EXIT_ADDR while `sup_mode` is 1 returns `state_q` to the captured state exactly in the next cycle. In that same cycle `sup_mode` is 0 and `exit_pulse` is 1.
- R6: Outside entry and exit cycles, `upd_en`=1 loads `upd_state` into `state_q` at the next edge, and `upd_en`=0 leaves `state_q` unchanged. This holds in both modes.
- R7: A request that is not taken in the cycle it arrives is held. This covers requests made in supervisor mode and requests made off an instruction boundary. A held request is taken at the first boundary after the block returns to user mode.
- R8: A write with `wr_addr`=CFG_ADDR while `sup_mode` is 1 loads `wr_data` into `cfg_q`. `overlay_en` equals bit 0 of `cfg_q`.
- R9: A write to CFG_ADDR or to EXIT_ADDR while `sup_mode` is 0 has no effect on `cfg_q`, `sup_mode`, `exit_pulse` or `state_q`.
- R10: `enter_pulse` and `exit_pulse` each last one cycle per event and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_boundary | input | 1 | Core is at an instruction boundary |
| trap_req | input | 1 | General trap request |
| key_evt | input | 1 | Keyboard-derived trap request |
| upd_en | input | 1 | Core commits new state this cycle |
| upd_state | input | SW (88) | State committed by the core |
| wr_en | input | 1 | Core store strobe |
| wr_addr | input | ADDR_W (16) | Store address |
| wr_data | input | 8 | Store data |
| state_q | output | SW (88) | Live architectural state |
| sup_mode | output | 1 | Supervisor mode active |
| enter_pulse | output | 1 | One-cycle pulse on entry |
| exit_pulse | output | 1 | One-cycle pulse on exit |
| cfg_q | output | 8 | Protected configuration byte |
| overlay_en | output | 1 | Display overlay enable |

## Verification
The hardest case to reach from the ports is a request that must wait through a whole supervisor session. It then has to survive the exit cycle and be taken only once a boundary appears after the exit. Random stimulus seldom lines up a request inside a session with a quiet stretch that follows. A directed sequence therefore raises `trap_req` mid-session, exits with `instr_boundary` low, and then opens a boundary. A second directed case commits an update in the very cycle of entry, to show that the committed value is the one that gets restored.

// File: rtl/trap_ctx_pkg.sv
package trap_ctx_pkg;
  localparam int DW   = 8;   // byte-wide registers
  localparam int PCW  = 16;  // program counter width
  localparam int MAPW = 16;  // width of one mapping register

  // bit offsets inside the flattened state vector
  localparam int OFS_SP    = 3 * DW;
  localparam int OFS_FLAGS = 4 * DW;
  localparam int OFS_PC    = 5 * DW;
  localparam int OFS_MAP   = 5 * DW + PCW;

  function automatic int state_width(input int nmap);
    return 5 * DW + PCW + nmap * MAPW;
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_q,
  input  logic boundary,
  input  logic trap_req,
  input  logic key_evt,
  output logic take_o
);
  logic pend_q, pend_d;
  logic any_req;

  always_comb begin
    any_req = pend_q | trap_req | key_evt;
    take_o  = !sup_q && boundary && any_req;
    pend_d  = take_o ? 1'b0 : any_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/priv_regs.sv
module priv_regs #(
  parameter int                 ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  EXIT_ADDR = '0,
  parameter logic [ADDR_W-1:0]  CFG_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_q,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              exit_o,
  output logic [7:0]        cfg_o
);
  logic       cfg_we;
  logic [7:0] cfg_q, cfg_d;

  always_comb begin
    exit_o = sup_q && wr_en && (wr_addr == EXIT_ADDR);
    cfg_we = sup_q && wr_en && (wr_addr == CFG_ADDR);
    cfg_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
  parameter int SW = 88
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [SW-1:0] cap_data,
  output logic [SW-1:0] shadow_o
);
  logic [SW-1:0] shd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shd_q <= '0;
    else if (cap_en) shd_q <= cap_data;
  end

  assign shadow_o = shd_q;
endmodule

// File: rtl/sup_image.sv
module sup_image
  import trap_ctx_pkg::*;
#(
  parameter int              NMAP         = 2,
  parameter int              SW           = state_width(NMAP),
  parameter logic [PCW-1:0]  SUP_PC       = '0,
  parameter logic [DW-1:0]   SUP_SP       = '0,
  parameter logic [DW-1:0]   SUP_FLAGS    = '0,
  parameter logic [MAPW-1:0] SUP_MAP_BASE = '0
) (
  input  logic [SW-1:0] cur_i,
  output logic [SW-1:0] img_o
);
  logic [NMAP*MAPW-1:0] map_img;

  // mapping register k gets its own supervisor window
  for (genvar k = 0; k < NMAP; k++) begin : g_map
    assign map_img[k*MAPW +: MAPW] = MAPW'(SUP_MAP_BASE + MAPW'(k));
  end

  always_comb begin
    img_o                          = cur_i;
    img_o[OFS_SP    +: DW]         = SUP_SP;
    img_o[OFS_FLAGS +: DW]         = SUP_FLAGS;
    img_o[OFS_PC    +: PCW]        = SUP_PC;
    img_o[OFS_MAP   +: NMAP*MAPW]  = map_img;
  end
endmodule

// File: rtl/trap_ctx_switch.sv
module trap_ctx_switch
  import trap_ctx_pkg::*;
#(
  parameter int                NMAP         = 2,
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] EXIT_ADDR    = 16'hFE7F,
  parameter logic [ADDR_W-1:0] CFG_ADDR     = 16'hFE7E,
  parameter logic [PCW-1:0]    SUP_PC       = 16'h8100,
  parameter logic [DW-1:0]     SUP_SP       = 8'hF0,
  parameter logic [DW-1:0]     SUP_FLAGS    = 8'h24,
  parameter logic [MAPW-1:0]   SUP_MAP_BASE = 16'h0F00,
  localparam int               SW           = state_width(NMAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_boundary,
  input  logic              trap_req,
  input  logic              key_evt,
  input  logic              upd_en,
  input  logic [SW-1:0]     upd_state,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [SW-1:0]     state_q,
  output logic              sup_mode,
  output logic              enter_pulse,
  output logic              exit_pulse,
  output logic [7:0]        cfg_q,
  output logic              overlay_en
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic          sup_q, sup_d;
  logic          ent_q, ext_q;
  logic [SW-1:0] live_q, live_d;
  logic [SW-1:0] eff_state, sup_img, shadow;
  logic          take, exit_w;

  trap_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_s),
    .sup_q    (sup_q),
    .boundary (instr_boundary),
    .trap_req (trap_req),
    .key_evt  (key_evt),
    .take_o   (take)
  );

  priv_regs #(
    .ADDR_W    (ADDR_W),
    .EXIT_ADDR (EXIT_ADDR),
    .CFG_ADDR  (CFG_ADDR)
  ) u_priv (
    .clk     (clk),
    .rst_n   (rst_s),
    .sup_q   (sup_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .exit_o  (exit_w),
    .cfg_o   (cfg_q)
  );

  // state in effect at this boundary, including a same-cycle commit
  assign eff_state = upd_en ? upd_state : live_q;

  shadow_bank #(.SW(SW)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_s),
    .cap_en   (take),
    .cap_data (eff_state),
    .shadow_o (shadow)
  );

  sup_image #(
    .NMAP         (NMAP),
    .SW           (SW),
    .SUP_PC       (SUP_PC),
    .SUP_SP       (SUP_SP),
    .SUP_FLAGS    (SUP_FLAGS),
    .SUP_MAP_BASE (SUP_MAP_BASE)
  ) u_img (
    .cur_i (eff_state),
    .img_o (sup_img)
  );

  // next-state selection
  always_comb begin
    sup_d  = sup_q;
    live_d = eff_state;
    if (take) begin
      sup_d  = 1'b1;
      live_d = sup_img;
    end else if (exit_w) begin
      sup_d  = 1'b0;
      live_d = shadow;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      sup_q  <= 1'b0;
      ent_q  <= 1'b0;
      ext_q  <= 1'b0;
      live_q <= '0;
    end else begin
      sup_q  <= sup_d;
      ent_q  <= take;
      ext_q  <= exit_w;
      live_q <= live_d;
    end
  end

  assign state_q     = live_q;
  assign sup_mode    = sup_q;
  assign enter_pulse = ent_q;
  assign exit_pulse  = ext_q;
  assign overlay_en  = cfg_q[0];
endmodule

// File: rtl/trap_ctx_checker.sv
module trap_ctx_checker
  import trap_ctx_pkg::*;
#(
  parameter int                SW       = 88,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = '0,
  parameter logic [PCW-1:0]    SUP_PC   = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sup_mode,
  input logic              enter_pulse,
  input logic              exit_pulse,
  input logic [SW-1:0]     state_q,
  input logic [7:0]        cfg_q,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr
);
  a_r2_enter_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    enter_pulse |-> sup_mode && !$past(sup_mode));

  a_r3_sup_pc: assert property (@(posedge clk) disable iff (!rst_n)
    enter_pulse |-> state_q[OFS_PC +: PCW] == SUP_PC);

  a_r5_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |-> !sup_mode && $past(sup_mode));

  a_r9_cfg_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CFG_ADDR && !sup_mode) |=> $stable(cfg_q));

  a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_pulse && exit_pulse));

  a_r10_enter_single: assert property (@(posedge clk) disable iff (!rst_n)
    enter_pulse |=> !enter_pulse);
endmodule

bind trap_ctx_switch trap_ctx_checker #(
  .SW       (SW),
  .ADDR_W   (ADDR_W),
  .CFG_ADDR (CFG_ADDR),
  .SUP_PC   (SUP_PC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_s),
  .sup_mode    (sup_mode),
  .enter_pulse (enter_pulse),
  .exit_pulse  (exit_pulse),
  .state_q     (state_q),
  .cfg_q       (cfg_q),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr)
);

// File: tb/trap_ctx_switch_bench.sv
module trap_ctx_switch_bench;
  localparam int          SW     = 88;
  localparam logic [15:0] A_EXIT = 16'hFE7F;
  localparam logic [15:0] A_CFG  = 16'hFE7E;
  localparam logic [15:0] S_PC   = 16'h8100;
  localparam logic [7:0]  S_SP   = 8'hF0;
  localparam logic [7:0]  S_FL   = 8'h24;
  localparam logic [15:0] S_MAP  = 16'h0F00;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          instr_boundary, trap_req, key_evt, upd_en, wr_en;
  logic [SW-1:0] upd_state;
  logic [15:0]   wr_addr;
  logic [7:0]    wr_data;
  logic [SW-1:0] state_q;
  logic          sup_mode, enter_pulse, exit_pulse, overlay_en;
  logic [7:0]    cfg_q;

  always #4 clk = ~clk;  // 125 MHz

  trap_ctx_switch u_trap_ctx_switch (
    .clk(clk), .rst_n(rst_n), .instr_boundary(instr_boundary),
    .trap_req(trap_req), .key_evt(key_evt), .upd_en(upd_en),
    .upd_state(upd_state), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .state_q(state_q), .sup_mode(sup_mode),
    .enter_pulse(enter_pulse), .exit_pulse(exit_pulse), .cfg_q(cfg_q),
    .overlay_en(overlay_en)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model
  logic [SW-1:0] m_st, m_shd;
  logic          m_sup, m_pend, m_ep, m_xp;
  logic [7:0]    m_cfg;

  function automatic logic [SW-1:0] sup_img(input logic [SW-1:0] s);
    logic [SW-1:0] r = s;
    r[31:24] = S_SP;
    r[39:32] = S_FL;
    r[55:40] = S_PC;
    r[71:56] = S_MAP;
    r[87:72] = S_MAP + 16'd1;
    return r;
  endfunction

  function automatic logic [SW-1:0] rnd_state();
    logic [95:0] v = {$urandom, $urandom, $urandom};
    return v[SW-1:0];
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [SW-1:0] act, input logic [SW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "sup_mode",    SW'(sup_mode),    SW'(m_sup));
    chk(tag, "enter_pulse", SW'(enter_pulse), SW'(m_ep));
    chk(tag, "exit_pulse",  SW'(exit_pulse),  SW'(m_xp));
    chk(tag, "state_q",     state_q,          m_st);
    chk(tag, "cfg_q",       SW'(cfg_q),       SW'(m_cfg));
    chk(tag, "overlay_en",  SW'(overlay_en),  SW'(m_cfg[0]));
  endtask

  // one cycle: drive at the falling edge, update model, compare next falling edge
  task automatic step(input string tag, input logic bnd, input logic tr,
                      input logic ke, input logic ue, input logic [SW-1:0] us,
                      input logic we, input logic [15:0] wa, input logic [7:0] wd);
    logic [SW-1:0] eff;
    logic take, exw;
    instr_boundary = bnd; trap_req = tr; key_evt = ke;
    upd_en = ue; upd_state = us; wr_en = we; wr_addr = wa; wr_data = wd;
    eff  = ue ? us : m_st;
    take = !m_sup && bnd && (m_pend || tr || ke);
    exw  = m_sup && we && wa == A_EXIT;
    if (m_sup && we && wa == A_CFG) m_cfg = wd;
    if (take) begin
      m_shd = eff; m_st = sup_img(eff); m_sup = 1'b1; m_pend = 1'b0;
    end else if (exw) begin
      m_st = m_shd; m_sup = 1'b0; m_pend = m_pend | tr | ke;
    end else begin
      m_st = eff; m_pend = m_pend | tr | ke;
    end
    m_ep = take; m_xp = exw;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 16'h0000, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] snap, st2;
    void'($urandom(32'h5EED_7A11));
    rst_n = 1'b0;
    instr_boundary = 0; trap_req = 0; key_evt = 0; upd_en = 0;
    upd_state = '0; wr_en = 0; wr_addr = '0; wr_data = '0;
    m_st = '0; m_shd = '0; m_sup = 0; m_pend = 0; m_ep = 0; m_xp = 0; m_cfg = '0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    repeat (4) idle("R1 after release");

    // R6: plain commits in user mode
    snap = rnd_state();
    step("R6 commit", 1'b0, 0, 0, 1'b1, snap, 0, 16'h0, 8'h0);
    idle("R6 hold");

    // R9: user-mode stores to exit trigger and protected register
    step("R9 exit in user", 1'b1, 0, 0, 0, '0, 1'b1, A_EXIT, 8'h00);
    step("R9 cfg in user",  1'b1, 0, 0, 0, '0, 1'b1, A_CFG,  8'hFF);

    // R4: commit in the entry cycle is the captured value; R2/R3 via key event
    st2 = rnd_state();
    step("R2 key entry R3 R4", 1'b1, 0, 1'b1, 1'b1, st2, 0, 16'h0, 8'h0);
    // R7: request inside supervisor session is held
    step("R7 req in sup", 1'b1, 1'b1, 0, 0, '0, 0, 16'h0, 8'h0);
    // R8: supervisor write to protected register
    step("R8 cfg write", 1'b0, 0, 0, 0, '0, 1'b1, A_CFG, 8'h01);
    // R6: supervisor code commits its own state
    step("R6 sup commit", 1'b0, 0, 0, 1'b1, rnd_state(), 0, 16'h0, 8'h0);
    // R5: exit restores st2 exactly, no boundary yet
    step("R5 exit restore", 1'b0, 0, 0, 0, '0, 1'b1, A_EXIT, 8'h00);
    idle("R7 held off-boundary");
    // R7: held request taken at the first boundary
    step("R7 held taken", 1'b1, 0, 0, 0, '0, 0, 16'h0, 8'h0);
    step("R10 pulse single", 1'b0, 0, 0, 0, '0, 0, 16'h0, 8'h0);
    step("R5 second exit", 1'b1, 0, 0, 0, '0, 1'b1, A_EXIT, 8'h00);
    step("R8 cfg kept in user", 1'b0, 0, 0, 0, '0, 1'b1, A_CFG, 8'h00);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] wa;
      int sel = $urandom_range(0, 3);
      wa = (sel == 0) ? A_EXIT : (sel == 1) ? A_CFG : 16'($urandom);
      step("RND R2 R5 R6 R7", 1'($urandom_range(0, 1)),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 15) == 0),
           1'($urandom_range(0, 1)), rnd_state(),
           ($urandom_range(0, 3) == 0), wa, 8'($urandom));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule